// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block forms the byte a host receives when it reads a flash array while an internal program or erase runs, or while an erase is paused. The command sequencer supplies the activity flag, the kind of operation, the byte being programmed, the mask of sectors chosen for erase, the read address, the array byte at that address, an expiry flag and an acceptance-window flag. The block returns either that array byte unchanged or a status word in which single bits report progress. It also drives an active-low ready/busy level.

Progress is reported through five bit positions. Bit 7 is a polarity bit for polling. Bit 6 flips on every status read while an algorithm is active. Bit 5 flags expiry. Bit 3 shows that the erase acceptance window has closed. Bit 2 flips only for reads inside a sector that is paused mid-erase. A read is signalled by a one-cycle strobe that stands for the rising edge of the read strobe. The returned byte is registered on that clock edge, and the toggle state advances on the same edge.

Top module: `fstat_reporter`

## Requirements
- R1: While reset is asserted (rst_n low at a clock edge), dout is 0x00 and ready is 1, and both toggle states are cleared.
- R2: dout is loaded only at a clock edge where rd_stb is 1. It holds its value while rd_stb is 0, whatever the other inputs do.
- R3: A read with busy = 0, or with op_kind = 2'b00, returns arr_data unmodified.
- R4: With busy = 1 and op_kind = 2'b01 (program), bit 7 of a read is the complement of tgt_data[7].
- R5: With busy = 1 and op_kind = 2'b10 (erase), bit 7 of a read is 0 and bit 3 equals win_closed.
- R6: During program or erase, bit 6 of the first read after idle is 0, and it alternates on each later read. The bit-6 state holds through an erase suspend and clears whenever busy is 0.
- R7: With busy = 1 and op_kind = 2'b11 (erase suspended), a read whose address top SECT_W bits select a sector set in erase_sel returns bit 7 = 1, bit 6 = the held bit-6 state, and bit 2 = the suspend toggle, with bits 5, 4, 3, 1 and 0 at 0. The suspend toggle starts at 0 on entry to suspend and alternates on each such read.
- R8: A read outside the erase_sel sectors during suspend returns arr_data and does not advance either toggle.
- R9: During program or erase, bit 5 of a read equals timeout.
- R10: During program or erase, bits 4, 2, 1 and 0 read 0.
- R11: ready is 0 in the cycle after any edge with busy = 1 and op_kind equal to program or erase. Otherwise it is 1, including during suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy | input | 1 | An embedded operation is in progress or suspended |
| op_kind | input | 2 | 01 program, 10 erase, 11 erase suspended, 00 none |
| tgt_data | input | 8 | Byte being programmed |
| erase_sel | input | NSECT (8) | One bit per sector chosen for erase |
| rd_addr | input | ADDR_W (19) | Read address; top SECT_W bits pick the sector |
| arr_data | input | 8 | Array byte at rd_addr |
| timeout | input | 1 | Operation exceeded its time limit |
| win_closed | input | 1 | Sector-erase acceptance window has closed |
| rd_stb | input | 1 | One-cycle pulse marking the end of a host read |
| dout | output | 8 | Byte returned to the host |
| ready | output | 1 | 1 ready, 0 busy |

## Verification
Every read result is due one cycle after the clock edge that samples rd_stb. The ready level is also due one cycle after the edge that samples busy and op_kind. The bench changes all inputs on the falling edge and lowers the strobe on the next falling edge, where it samples dout. That falling edge falls half a period after the only register update that affects the result. Toggle expectations come from a bench model that flips a bit per qualifying read and clears it on the idle and suspend-exit rules given above.

// File: rtl/fstat_pkg.sv
// Package: shared encodings and bit positions of the status reporter.
// Assumes an 8-bit data path; status bit positions are fixed by the host protocol.
package fstat_pkg;
    typedef enum logic [1:0] {
        OPK_NONE  = 2'b00,
        OPK_PROG  = 2'b01,
        OPK_ERASE = 2'b10,
        OPK_ESUSP = 2'b11
    } opk_t;

    localparam int DW     = 8;
    localparam int B_POLL = 7;
    localparam int B_TOG  = 6;
    localparam int B_TMO  = 5;
    localparam int B_WIN  = 3;
    localparam int B_STOG = 2;
endpackage

// File: rtl/fstat_toggle.sv
// Module: a single toggle state bit.
// It clears while clr is high, otherwise inverts whenever adv is high.
// Assumes clr takes priority over adv.
module fstat_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic q
);
    // Toggle register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (clr) q <= 1'b0;
        else if (adv) q <= ~q;
    end
endmodule

// File: rtl/fstat_sector_hit.sv
// Module: decides whether a read address falls in a sector selected for erase.
// Sector index is the top SECT_W address bits; uniform sectors are assumed.
module fstat_sector_hit #(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 3
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [(1<<SECT_W)-1:0]  sel,
    output logic                    hit
);
    localparam int NSECT = 1 << SECT_W;

    logic [SECT_W-1:0] sidx;
    logic [NSECT-1:0]  dec;

    assign sidx = addr[ADDR_W-1 -: SECT_W];

    // One comparator per sector forms a one-hot decode.
    for (genvar i = 0; i < NSECT; i++) begin : g_dec
        assign dec[i] = (sidx == SECT_W'(i));
    end

    // Hit when the decoded sector is one of the selected ones.
    always_comb hit = |(dec & sel);
endmodule

// File: rtl/fstat_word.sv
// Module: combinational builder of the byte returned for one read.
// Assumes busy and op have already been qualified by the caller's flags.
module fstat_word
    import fstat_pkg::*;
(
    input  logic          active,
    input  logic          susp_hit,
    input  opk_t          op,
    input  logic          tgt7,
    input  logic          timeout,
    input  logic          win_closed,
    input  logic          tog6,
    input  logic          tog2,
    input  logic [DW-1:0] arr,
    output logic [DW-1:0] word
);
    // Select status layout by operation kind, else pass array data.
    always_comb begin
        word = arr;
        if (active) begin
            word         = '0;
            word[B_TOG]  = tog6;
            word[B_TMO]  = timeout;
            if (op == OPK_PROG) begin
                word[B_POLL] = ~tgt7;
            end else begin
                word[B_POLL] = 1'b0;
                word[B_WIN]  = win_closed;
            end
        end else if (susp_hit) begin
            word         = '0;
            word[B_POLL] = 1'b1;
            word[B_TOG]  = tog6;
            word[B_STOG] = tog2;
        end
    end
endmodule

// File: rtl/fstat_reporter.sv
// Module: top of the embedded operation status reporter.
// Returns a registered read byte on each rd_stb and drives the ready/busy level.
// Assumes rd_stb is a one-cycle pulse per host read and that inputs are synchronous to clk.
module fstat_reporter
    import fstat_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   busy,
    input  logic [1:0]             op_kind,
    input  logic [7:0]             tgt_data,
    input  logic [(1<<SECT_W)-1:0] erase_sel,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [7:0]             arr_data,
    input  logic                   timeout,
    input  logic                   win_closed,
    input  logic                   rd_stb,
    output logic [7:0]             dout,
    output logic                   ready
);
    opk_t          op;
    logic          active;
    logic          in_susp;
    logic          sect_hit;
    logic          susp_hit;
    logic          tog6;
    logic          tog2;
    logic [DW-1:0] word;

    // Decode operation kind into qualified modes.
    always_comb begin
        op       = opk_t'(op_kind);
        active   = busy && (op == OPK_PROG || op == OPK_ERASE);
        in_susp  = busy && (op == OPK_ESUSP);
        susp_hit = in_susp && sect_hit;
    end

    fstat_sector_hit #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_hit (
        .addr (rd_addr),
        .sel  (erase_sel),
        .hit  (sect_hit)
    );

    fstat_toggle u_tog6 (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!busy),
        .adv   (rd_stb && active),
        .q     (tog6)
    );

    fstat_toggle u_tog2 (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!in_susp),
        .adv   (rd_stb && susp_hit),
        .q     (tog2)
    );

    fstat_word u_word (
        .active     (active),
        .susp_hit   (susp_hit),
        .op         (op),
        .tgt7       (tgt_data[B_POLL]),
        .timeout    (timeout),
        .win_closed (win_closed),
        .tog6       (tog6),
        .tog2       (tog2),
        .arr        (arr_data),
        .word       (word)
    );

    // Capture the read byte on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      dout <= '0;
        else if (rd_stb) dout <= word;
    end

    // Ready/busy level: low while an algorithm runs.
    always_ff @(posedge clk) begin
        if (!rst_n) ready <= 1'b1;
        else        ready <= !active;
    end
endmodule

// File: rtl/fstat_chk.sv
// Module: assertion checker for fstat_reporter, attached by bind.
// Assumes the port encodings stated in the requirements.
module fstat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic [1:0] op_kind,
    input logic [7:0] tgt_data,
    input logic [7:0] arr_data,
    input logic       timeout,
    input logic       win_closed,
    input logic       rd_stb,
    input logic [7:0] dout,
    input logic       ready
);
    logic run;
    assign run = busy && (op_kind == 2'b01 || op_kind == 2'b10);

    // R2
    hold_dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(dout));
    // R3
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !busy) |=> dout == $past(arr_data));
    // R4
    prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy && op_kind == 2'b01) |=> dout[7] == !$past(tgt_data[7]));
    // R5
    erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy && op_kind == 2'b10) |=> (!dout[7] && dout[3] == $past(win_closed)));
    // R9
    tmo_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && run) |=> dout[5] == $past(timeout));
    // R10
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && run) |=> (dout[4] == 1'b0 && dout[2:0] == 3'b000));
    // R11
    busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> !ready);
    // R11
    ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ready);
endmodule

bind fstat_reporter fstat_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .op_kind    (op_kind),
    .tgt_data   (tgt_data),
    .arr_data   (arr_data),
    .timeout    (timeout),
    .win_closed (win_closed),
    .rd_stb     (rd_stb),
    .dout       (dout),
    .ready      (ready)
);

// File: tb/fstat_reporter_tb.sv
// Bench: directed scenarios, one task each, with an independent toggle model.
module fstat_reporter_tb_top;
    localparam int ADDR_W = 19;
    localparam int SECT_W = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        busy = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic [7:0]  tgt_data = 8'h00;
    logic [7:0]  erase_sel = 8'h00;
    logic [18:0] rd_addr = '0;
    logic [7:0]  arr_data = 8'h00;
    logic        timeout = 1'b0;
    logic        win_closed = 1'b0;
    logic        rd_stb = 1'b0;
    logic [7:0]  dout;
    logic        ready;

    int checks = 0;
    int errors = 0;
    bit m6 = 1'b0;
    bit m2 = 1'b0;

    always #5 clk = ~clk;

    fstat_reporter #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .busy(busy), .op_kind(op_kind),
        .tgt_data(tgt_data), .erase_sel(erase_sel), .rd_addr(rd_addr),
        .arr_data(arr_data), .timeout(timeout), .win_closed(win_closed),
        .rd_stb(rd_stb), .dout(dout), .ready(ready)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // One read at sector s, offset 0; result sampled one edge later.
    task automatic rd(input int s, output logic [7:0] v);
        @(negedge clk);
        rd_addr = {3'(s), 16'h0123};
        rd_stb  = 1'b1;
        @(negedge clk);
        rd_stb  = 1'b0;
        v = dout;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 dout", dout, 8'h00);
        check("R1 ready", {7'b0, ready}, 8'h01);
        rst_n = 1'b1;
    endtask

    task automatic t_idle();
        logic [7:0] v;
        arr_data = 8'hA5; rd(1, v); check("R3 idle a5", v, 8'hA5);
        arr_data = 8'h3C; rd(6, v); check("R3 idle 3c", v, 8'h3C);
        @(negedge clk); arr_data = 8'hFF; busy = 1'b1; op_kind = 2'b00;
        repeat (2) @(negedge clk);
        check("R2 hold", dout, 8'h3C);
        rd(0, v); check("R3 none-op", v, 8'hFF);
        busy = 1'b0;
    endtask

    task automatic t_program();
        logic [7:0] v;
        @(negedge clk); busy = 1'b1; op_kind = 2'b01; tgt_data = 8'h80;
        @(negedge clk); check("R11 busy prog", {7'b0, ready}, 8'h00);
        for (int i = 0; i < 3; i++) begin
            rd(2, v);
            check("R4 R6 R10 prog", v, {~tgt_data[7], m6, 6'b0});
            m6 = ~m6;
        end
        tgt_data = 8'h11; timeout = 1'b1;
        rd(2, v); check("R4 R9 prog tmo", v, {1'b1, m6, 1'b1, 5'b0}); m6 = ~m6;
        timeout = 1'b0;
        @(negedge clk); busy = 1'b0; m6 = 1'b0; arr_data = 8'h77;
        @(negedge clk); check("R11 idle ready", {7'b0, ready}, 8'h01);
        rd(2, v); check("R3 after prog", v, 8'h77);
    endtask

    task automatic t_erase_suspend();
        logic [7:0] v;
        @(negedge clk); busy = 1'b1; op_kind = 2'b10; erase_sel = 8'b0000_0100;
        rd(2, v); check("R5 R6 erase", v, {2'b00, m6, 5'b0}); m6 = ~m6;
        win_closed = 1'b1;
        rd(2, v); check("R5 erase win", v, {1'b0, m6, 2'b00, 1'b1, 3'b0}); m6 = ~m6;
        timeout = 1'b1;
        rd(3, v); check("R9 erase tmo", v, {1'b0, m6, 1'b1, 1'b0, 1'b1, 3'b0}); m6 = ~m6;
        timeout = 1'b0;
        op_kind = 2'b11; arr_data = 8'h5A;
        @(negedge clk); check("R11 ready susp", {7'b0, ready}, 8'h01);
        for (int i = 0; i < 3; i++) begin
            rd(2, v); check("R7 susp in", v, {1'b1, m6, 3'b0, m2, 2'b0}); m2 = ~m2;
        end
        rd(5, v); check("R8 susp out", v, 8'h5A);
        rd(2, v); check("R7 R8 no adv", v, {1'b1, m6, 3'b0, m2, 2'b0}); m2 = ~m2;
        op_kind = 2'b10; m2 = 1'b0;
        rd(2, v); check("R6 resume", v, {1'b0, m6, 2'b00, 1'b1, 3'b0}); m6 = ~m6;
        op_kind = 2'b11;
        rd(2, v); check("R7 reentry", v, {1'b1, m6, 3'b0, 1'b0, 2'b0});
        @(negedge clk); busy = 1'b0; m6 = 1'b0; m2 = 1'b0; win_closed = 1'b0;
        @(negedge clk); op_kind = 2'b01; busy = 1'b1; tgt_data = 8'h00;
        rd(1, v); check("R6 first after idle", v, 8'h80);
        busy = 1'b0;
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog: got hang expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        t_program();
        t_erase_suspend();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule